// File: doc/BRIEF.md
# Parallel Sample Input Staging Unit

This block sits between a host processor and a sample-processing datapath. The host writes an in-phase word and a quadrature word into two holding registers over a narrow parallel write port. It then sets a ready flag in a small status register. At each sample strobe from the datapath, the block takes the held pair and presents it on a registered output stream. On the strobe that uses up a pair, it clears the ready flag and raises a request line, which the host can treat as an interrupt and use in place of polling.

If a pair is taken while the ready flag is still clear, the host was late. The block then sets a sticky missed flag, which stays set until the host rewrites the status register. When the host relies only on the request line and never sets ready, the missed flag has no meaning.

A mode input packs two real samples into one pair: the earlier sample goes in the I word and the later one in the Q word. Each of the two is emitted on its own strobe. A parameter builds a complex-only variant that ignores this mode. A second parameter selects whether the request is a one-clock pulse or a level that is held until the next host write.

Top module: `sample_in_stage`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `ready`, `missed`, `req` and `out_valid` are all 0.
- R2: A write with `wr_sel`=0 loads the I holding word and `wr_sel`=1 loads the Q holding word. In complex mode, a `strobe` makes `out_valid`=1 on the next clock, with `out_i`/`out_q` equal to the held I/Q words.
- R3: A write with `wr_sel`=2 goes to the status register. `ready` takes the value of data bit 0. Bit 1 = 0 clears `missed`, and bit 1 = 1 leaves `missed` unchanged.
- R4: The strobe that uses up a pair clears `ready` and asserts `req`, and both are visible on the next clock.
- R5: `missed` becomes 1 only when a strobe starts a new pair while `ready` is 0. Once set, it stays 1 until a status write with bit 1 = 0.
- R6: With `real_mode`=1, the first strobe of a pair emits the I word and the second emits the Q word, both on `out_i` with `out_q`=0. `ready` is cleared and `req` raised only after the second strobe.
- R7: With parameter `REAL_EN`=0, `real_mode` is ignored, and every strobe emits the whole pair as one complex sample.
- R8: With `REQ_PULSE`=1, `req` is high for exactly one clock. With `REQ_PULSE`=0, it stays high until the next host write of any kind.
- R9: A status write with bit 0 = 1 in the same cycle as a pair-consuming strobe leaves `ready` at 1, while `req` still asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Write target: 0 = I word, 1 = Q word, 2 = status |
| wr_data | input | DATA_W | Host write data |
| real_mode | input | 1 | 1 = two real samples per pair |
| strobe | input | 1 | Datapath sample strobe |
| ready | output | 1 | Ready flag (status bit 0) |
| missed | output | 1 | Sticky missed-sample flag (status bit 1) |
| req | output | 1 | Load request / interrupt |
| out_valid | output | 1 | Output sample valid |
| out_i | output | DATA_W | Output I (or real sample) |
| out_q | output | DATA_W | Output Q (0 in real mode) |

## Verification
The hardest case to reach is a host status write that lands in the same clock as the strobe that uses up a pair. Only the exact alignment of those two events shows whether the early reload survives the hardware clear. The bench puts both in a single stimulus cycle and then checks `ready`, `req` and the output pair on the following clock. It also makes the missed flag fire, then rewrites status with the keep bit set before clearing it, to show that the flag is sticky.

// File: rtl/sis_pkg.sv
package sis_pkg;
  typedef enum logic [1:0] {
    SEL_I    = 2'd0,
    SEL_Q    = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  localparam int STAT_RDY_BIT  = 0;
  localparam int STAT_KEEP_BIT = 1;
endpackage

// File: rtl/sis_hold_regs.sv
module sis_hold_regs
  import sis_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] hold_i,
  output logic [DATA_W-1:0] hold_q
);
  localparam int NWORD = 2;

  logic [DATA_W-1:0] words [NWORD];

  for (genvar g = 0; g < NWORD; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        words[g] <= '0;
      else if (wr_en && (wr_sel == 2'(g)))
        words[g] <= wr_data;
    end
  end

  assign hold_i = words[SEL_I];
  assign hold_q = words[SEL_Q];
endmodule

// File: rtl/sis_sequencer.sv
module sis_sequencer #(
  parameter int DATA_W  = 16,
  parameter bit REAL_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              real_mode,
  input  logic [DATA_W-1:0] hold_i,
  input  logic [DATA_W-1:0] hold_q,
  output logic              first_rd,
  output logic              last_rd,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_i,
  output logic [DATA_W-1:0] out_q
);
  logic eff_real;
  logic phase_q;

  if (REAL_EN) begin : g_real
    assign eff_real = real_mode;
  end else begin : g_cplx
    assign eff_real = 1'b0;
  end

  assign first_rd = strobe && !phase_q;
  assign last_rd  = strobe && (phase_q || !eff_real);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= 1'b0;
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= strobe;
      if (strobe) begin
        if (!eff_real) begin
          out_i   <= hold_i;
          out_q   <= hold_q;
          phase_q <= 1'b0;
        end else if (!phase_q) begin
          out_i   <= hold_i;
          out_q   <= '0;
          phase_q <= 1'b1;
        end else begin
          out_i   <= hold_q;
          out_q   <= '0;
          phase_q <= 1'b0;
        end
      end
    end
  end

  // R2
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(strobe));

  // R7
  phase_cplx_chk: assert property (@(posedge clk) disable iff (rst)
    !REAL_EN |-> !phase_q);

  // R6
  real_q_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (REAL_EN && $past(strobe && real_mode)) |-> (out_q == '0));
endmodule

// File: rtl/sis_flags.sv
module sis_flags
  import sis_pkg::*;
#(
  parameter bit REQ_PULSE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic any_wr,
  input  logic stat_wr,
  input  logic wr_rdy,
  input  logic wr_keep,
  input  logic first_rd,
  input  logic last_rd,
  output logic ready_q,
  output logic missed_q,
  output logic req_q
);
  always_ff @(posedge clk) begin
    if (rst)
      ready_q <= 1'b0;
    else if (stat_wr)
      ready_q <= wr_rdy;
    else if (last_rd)
      ready_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)
      missed_q <= 1'b0;
    else if (first_rd && !ready_q)
      missed_q <= 1'b1;
    else if (stat_wr && !wr_keep)
      missed_q <= 1'b0;
  end

  if (REQ_PULSE) begin : g_pulse
    always_ff @(posedge clk) begin
      if (rst) req_q <= 1'b0;
      else     req_q <= last_rd;
    end

    // R8
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      req_q |=> (!req_q || $past(last_rd)));
  end else begin : g_level
    always_ff @(posedge clk) begin
      if (rst)          req_q <= 1'b0;
      else if (last_rd) req_q <= 1'b1;
      else if (any_wr)  req_q <= 1'b0;
    end

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (req_q && !any_wr) |=> req_q);
  end

  // R4
  ready_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(last_rd && !stat_wr) |-> !ready_q);

  // R4
  req_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_q) |-> $past(last_rd));

  // R5
  missed_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(missed_q) |-> $past(first_rd && !ready_q));

  // R5
  missed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (missed_q && !(stat_wr && !wr_keep)) |=> missed_q);

  // R9
  ready_win_chk: assert property (@(posedge clk) disable iff (rst)
    $past(stat_wr && wr_rdy) |-> ready_q);
endmodule

// File: rtl/sample_in_stage.sv
module sample_in_stage
  import sis_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter bit REAL_EN   = 1'b1,
  parameter bit REQ_PULSE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              real_mode,
  input  logic              strobe,
  output logic              ready,
  output logic              missed,
  output logic              req,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_i,
  output logic [DATA_W-1:0] out_q
);
  logic [DATA_W-1:0] hold_i, hold_q;
  logic first_rd, last_rd;
  logic stat_wr;

  assign stat_wr = wr_en && (sel_e'(wr_sel) == SEL_STAT);

  sis_hold_regs #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .hold_i(hold_i), .hold_q(hold_q)
  );

  sis_sequencer #(.DATA_W(DATA_W), .REAL_EN(REAL_EN)) u_seq (
    .clk(clk), .rst(rst), .strobe(strobe), .real_mode(real_mode),
    .hold_i(hold_i), .hold_q(hold_q), .first_rd(first_rd), .last_rd(last_rd),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  sis_flags #(.REQ_PULSE(REQ_PULSE)) u_flags (
    .clk(clk), .rst(rst), .any_wr(wr_en), .stat_wr(stat_wr),
    .wr_rdy(wr_data[STAT_RDY_BIT]), .wr_keep(wr_data[STAT_KEEP_BIT]),
    .first_rd(first_rd), .last_rd(last_rd),
    .ready_q(ready), .missed_q(missed), .req_q(req)
  );
endmodule

// File: tb/test_sample_in_stage.sv
module test_sample_in_stage;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int VW = 57;
  localparam int NV = 14;

  // [56] wr [55:54] sel [53:38] data [37] strobe [36] real
  // [35] exp ready [34] exp missed [33] exp req [32] exp valid [31:16] exp i [15:0] exp q
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1, 2'd0, 16'h1111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {1'b1, 2'd1, 16'h2222, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {1'b1, 2'd2, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h1111, 16'h2222},
    {1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h1111, 16'h2222},
    {1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {1'b1, 2'd2, 16'h0002, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {1'b1, 2'd0, 16'h0A0A, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {1'b1, 2'd1, 16'h0B0B, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {1'b1, 2'd2, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000},
    {1'b0, 2'd0, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0A0A, 16'h0000},
    {1'b0, 2'd0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0B0B, 16'h0000},
    {1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [DW-1:0] wr_data = '0;
  logic real_mode = 1'b0;
  logic strobe = 1'b0;

  logic rdy_a, mis_a, req_a, vld_a;
  logic [DW-1:0] oi_a, oq_a;
  logic rdy_b, mis_b, req_b, vld_b;
  logic [DW-1:0] oi_b, oq_b;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_in_stage #(.DATA_W(DW)) i_sample_in_stage (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .real_mode(real_mode), .strobe(strobe),
    .ready(rdy_a), .missed(mis_a), .req(req_a), .out_valid(vld_a),
    .out_i(oi_a), .out_q(oq_a)
  );

  sample_in_stage #(.DATA_W(DW), .REAL_EN(1'b0), .REQ_PULSE(1'b0)) i_sample_in_stage_c (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .real_mode(real_mode), .strobe(strobe),
    .ready(rdy_b), .missed(mis_b), .req(req_b), .out_valid(vld_b),
    .out_i(oi_b), .out_q(oq_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [1:0] s, input logic [DW-1:0] d,
                       input logic st, input logic rm);
    wr_en = w; wr_sel = s; wr_data = d; strobe = st; real_mode = rm;
  endtask

  task automatic do_reset();
    @(negedge clk);
    drive(1'b0, 2'd0, '0, 1'b0, 1'b0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 ready", rdy_a, 0);
    chk("R1 missed", mis_a, 0);
    chk("R1 req", req_a, 0);
    chk("R1 valid", vld_a, 0);
    chk("R1 req level", req_b, 0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    for (int k = 0; k < NV; k++) begin
      logic [VW-1:0] v;
      v = VEC[k];
      drive(v[56], v[55:54], v[53:38], v[37], v[36]);
      @(negedge clk);
      chk($sformatf("R3/R5 ready vec%0d", k), rdy_a, v[35]);
      chk($sformatf("R5 missed vec%0d", k), mis_a, v[34]);
      chk($sformatf("R4/R8 req vec%0d", k), req_a, v[33]);
      chk($sformatf("R2/R6 valid vec%0d", k), vld_a, v[32]);
      if (v[32]) begin
        chk($sformatf("R2/R6 out_i vec%0d", k), oi_a, v[31:16]);
        chk($sformatf("R2/R6 out_q vec%0d", k), oq_a, v[15:0]);
      end
    end

    // R9: early reload in the same cycle as the consuming strobe
    drive(1'b1, 2'd2, 16'h0001, 1'b0, 1'b0);
    @(negedge clk);
    chk("R3 ready set", rdy_a, 1);
    drive(1'b1, 2'd2, 16'h0001, 1'b1, 1'b0);
    @(negedge clk);
    chk("R9 ready kept", rdy_a, 1);
    chk("R9 req", req_a, 1);
    chk("R9 missed", mis_a, 0);
    chk("R9 out_i", oi_a, 16'h0A0A);
    chk("R9 out_q", oq_a, 16'h0B0B);

    // R7 / R8: complex-only, level request
    do_reset();
    drive(1'b1, 2'd0, 16'h0005, 1'b0, 1'b1); @(negedge clk);
    drive(1'b1, 2'd1, 16'h0006, 1'b0, 1'b1); @(negedge clk);
    drive(1'b1, 2'd2, 16'h0001, 1'b0, 1'b1); @(negedge clk);
    drive(1'b0, 2'd0, 16'h0000, 1'b1, 1'b1); @(negedge clk);
    chk("R7 valid", vld_b, 1);
    chk("R7 out_i", oi_b, 16'h0005);
    chk("R7 out_q", oq_b, 16'h0006);
    chk("R7 ready cleared", rdy_b, 0);
    chk("R8 level req set", req_b, 1);
    drive(1'b0, 2'd0, 16'h0000, 1'b0, 1'b1); @(negedge clk);
    chk("R8 level req held", req_b, 1);
    chk("R8 pulse req dropped", req_a, 0);
    drive(1'b1, 2'd0, 16'h0007, 1'b0, 1'b1); @(negedge clk);
    chk("R8 level req cleared by write", req_b, 0);
    drive(1'b0, 2'd0, 16'h0000, 1'b0, 1'b0); @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule